// File: doc/BRIEF.md
# Key Event Queue with Merged Status Byte

This block stores debounced key events from a matrix of up to 64 keys until a host collects them. Each event carries a 6-bit key number and a flag that marks it as a press or a release. Events wait in a 16-deep first-in first-out store. The host collects them one at a time with a read strobe.

A single byte is always presented to the host. It describes the oldest queued event and also says whether more events are waiting behind it. When the queue is empty, the byte holds a reserved code. The byte also reports, once, that an event was lost because the queue was full. Key numbers 62 and 63 share their encoding with these status codes. For those two keys the flag bits read as zero, and the host must read again to learn whether more data follows.

The number of stored entries is exported so that a separate interrupt generator can compare it against a threshold.

Top module: `key_event_queue`

## Requirements
- R1: The queue holds at most 16 events, and `entry_count` reports the number stored (0 to 16).
- R2: For a queued event with key number below 62, `rd_byte[5:0]` is the key number and `rd_byte[6]` is 1 for a release and 0 for a press. `rd_byte[7]` is 1 when at least one more event is queued behind it.
- R3: For a queued event with key number 62 or 63, `rd_byte[7:6]` reads 2'b00 and `rd_byte[5:0]` is the key number.
- R4: While `cfg_keep_release` is 0, a release event is discarded and changes neither the count nor the overflow flag.
- R5: With the queue empty and no overflow pending, `rd_byte` is 8'h3F. A read in that state leaves the count at 0.
- R6: An accepted event that arrives while 16 events are stored and no entry is popped in the same cycle is dropped. `overflow` is 1 from the next cycle, and the count stays at 16.
- R7: While `overflow` is 1, `rd_byte` is 8'h7E. The next read clears `overflow` and removes no event.
- R8: An accepted event and a read of a non-empty queue in the same cycle leave the count unchanged. This also holds with 16 stored, where the event is kept.
- R9: Events leave in the order they were accepted. A read at a cycle's edge removes exactly the event that `rd_byte` showed before that edge.
- R10: After reset the count is 0, `overflow` is 0 and `rd_byte` is 8'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_keep_release | input | 1 | 1: queue releases as well as presses; 0: presses only |
| ev_valid | input | 1 | One-cycle strobe offering a debounced key event |
| ev_key | input | 6 | Key number of the offered event |
| ev_release | input | 1 | 1 = release event, 0 = press event |
| rd_strobe | input | 1 | One-cycle host read; consumes the byte currently shown |
| rd_byte | output | 8 | Byte the host reads: event plus status, or a status code |
| entry_count | output | 5 | Number of queued events |
| overflow | output | 1 | An event was dropped and not yet reported by a read |

## Verification
The hardest case to reach is a read and a new event in the same cycle while the queue is full and an overflow report is pending. The bench reaches it by filling all sixteen slots, offering one more event to raise the overflow, and spending one read on the 7E report. It then applies a push and a read together at full depth. Draining the queue afterwards shows that the first key left, the late key landed last, and the more-data bit cleared only on the final entry.

// File: rtl/keyq_pkg.sv
package keyq_pkg;

    localparam int KEY_W = 6;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] EMPTY_CODE = 8'h3F;
    localparam logic [BYTE_W-1:0] OVF_CODE   = 8'h7E;

    typedef struct packed {
        logic             rel;
        logic [KEY_W-1:0] key;
    } key_ev_t;

endpackage

// File: rtl/keyq_ctrl.sv
module keyq_ctrl #(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_keep_release,
    input  logic             ev_valid,
    input  logic             ev_release,
    input  logic             rd_strobe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic accept, pop, push, drop, full, empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        full   = (st_q.cnt == CNT_W'(DEPTH));
        empty  = (st_q.cnt == '0);
        accept = ev_valid & (~ev_release | cfg_keep_release);
        // a pending overflow report absorbs the read; empty reads pop nothing
        pop    = rd_strobe & ~st_q.ovf & ~empty;
        push   = accept & (~full | pop);
        drop   = accept & full & ~pop;

        if (push) st_d.wr = bump(st_q.wr);
        if (pop)  st_d.rd = bump(st_q.rd);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
        st_d.ovf = drop | (st_q.ovf & ~rd_strobe);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en  = push;
    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign count  = st_q.cnt;
    assign ovf    = st_q.ovf;

endmodule

// File: rtl/keyq_store.sv
module keyq_store
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  key_ev_t          wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output key_ev_t          head
);

    key_ev_t mem_d [DEPTH];
    key_ev_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) mem_d[wr_ptr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign head = mem_q[rd_ptr];

endmodule

// File: rtl/keyq_fmt.sv
module keyq_fmt
    import keyq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  key_ev_t           head,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf,
    output logic [BYTE_W-1:0] byte_out
);

    logic status_key;

    always_comb begin
        // keys 62 and 63 collide with the status codes
        status_key = (head.key[KEY_W-1:1] == '1);
        if (ovf) begin
            byte_out = OVF_CODE;
        end else if (count == '0) begin
            byte_out = EMPTY_CODE;
        end else if (status_key) begin
            byte_out = {2'b00, head.key};
        end else begin
            byte_out = {(count > CNT_W'(1)), head.rel, head.key};
        end
    end

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_keep_release,
    input  logic             ev_valid,
    input  logic [5:0]       ev_key,
    input  logic             ev_release,
    input  logic             rd_strobe,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] entry_count,
    output logic             overflow
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    key_ev_t          wr_data, head;

    assign wr_data = '{rel: ev_release, key: ev_key};

    keyq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_keep_release (cfg_keep_release),
        .ev_valid         (ev_valid),
        .ev_release       (ev_release),
        .rd_strobe        (rd_strobe),
        .wr_en            (wr_en),
        .wr_ptr           (wr_ptr),
        .rd_ptr           (rd_ptr),
        .count            (entry_count),
        .ovf              (overflow)
    );

    keyq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .head    (head)
    );

    keyq_fmt #(.CNT_W(CNT_W)) u_fmt (
        .head     (head),
        .count    (entry_count),
        .ovf      (overflow),
        .byte_out (rd_byte)
    );

endmodule

// File: rtl/keyq_checker.sv
module keyq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_keep_release,
    input logic             ev_valid,
    input logic [5:0]       ev_key,
    input logic             ev_release,
    input logic             rd_strobe,
    input logic [7:0]       rd_byte,
    input logic [CNT_W-1:0] entry_count,
    input logic             overflow
);

    logic accepted;
    assign accepted = ev_valid & (~ev_release | cfg_keep_release) & (ev_key <= 6'd63);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(DEPTH));

    p_more_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && entry_count >= CNT_W'(2) && rd_byte[5:0] < 6'd62) |-> rd_byte[7]);

    p_status_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && entry_count != '0 && rd_byte[5:1] == 5'b11111) |-> rd_byte[7:6] == 2'b00);

    p_release_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_release && !cfg_keep_release && !rd_strobe)
        |=> (entry_count == $past(entry_count) && overflow == $past(overflow)));

    p_empty_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_count == '0 && !overflow) |-> rd_byte == 8'h3F);

    p_no_overflow_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && entry_count == CNT_W'(DEPTH) && !rd_strobe)
        |=> (overflow && entry_count == CNT_W'(DEPTH)));

    p_ovf_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> rd_byte == 8'h7E);

    p_ovf_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && rd_strobe && !ev_valid)
        |=> (!overflow && entry_count == $past(entry_count)));

    p_push_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && rd_strobe && !overflow && entry_count != '0)
        |=> entry_count == $past(entry_count));

endmodule

bind key_event_queue keyq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_keyq_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_keep_release (cfg_keep_release),
    .ev_valid         (ev_valid),
    .ev_key           (ev_key),
    .ev_release       (ev_release),
    .rd_strobe        (rd_strobe),
    .rd_byte          (rd_byte),
    .entry_count      (entry_count),
    .overflow         (overflow)
);

// File: tb/test_key_event_queue.sv
module test_key_event_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_keep_release = 1'b1;
    logic       ev_valid = 1'b0;
    logic [5:0] ev_key = '0;
    logic       ev_release = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_byte;
    logic [4:0] entry_count;
    logic       overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    key_event_queue i_key_event_queue (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_keep_release (cfg_keep_release),
        .ev_valid         (ev_valid),
        .ev_key           (ev_key),
        .ev_release       (ev_release),
        .rd_strobe        (rd_strobe),
        .rd_byte          (rd_byte),
        .entry_count      (entry_count),
        .overflow         (overflow)
    );

    // {exp_byte, exp_count, exp_ovf, valid, key, release, keep_release, read}
    // expectations describe the state before the vector's stimulus is applied
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {8'h3F, 5'd0, 1'b0, 1'b1, 6'd5,  1'b0, 1'b1, 1'b0}, // R10 idle; push 5 press
        {8'h05, 5'd1, 1'b0, 1'b1, 6'd10, 1'b1, 1'b1, 1'b0}, // R2 single; push 10 release
        {8'h85, 5'd2, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1}, // R2 more bit; read
        {8'h4A, 5'd1, 1'b0, 1'b1, 6'd7,  1'b1, 1'b0, 1'b0}, // R2 release bit; R4 filtered release
        {8'h4A, 5'd1, 1'b0, 1'b1, 6'd7,  1'b0, 1'b1, 1'b1}, // R4 unchanged; R8 push+pop
        {8'h07, 5'd1, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1}, // R8 count kept; read
        {8'h3F, 5'd0, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1}, // R5 read of empty
        {8'h3F, 5'd0, 1'b0, 1'b1, 6'd63, 1'b0, 1'b1, 1'b0}, // R5 still empty; push 63
        {8'h3F, 5'd1, 1'b0, 1'b1, 6'd62, 1'b1, 1'b1, 1'b0}, // R3 key 63; push 62 release
        {8'h3F, 5'd2, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1}, // R3 flags cleared; read
        {8'h3E, 5'd1, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b1}, // R3 key 62; read
        {8'h3F, 5'd0, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0}  // R9 drained in order
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] k, input logic rel,
                         input logic keep, input logic rd);
        ev_valid         = v;
        ev_key           = k;
        ev_release       = rel;
        cfg_keep_release = keep;
        rd_strobe        = rd;
        @(negedge clk);
        ev_valid  = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 byte", rd_byte, 8'h3F);
        check("R10 count", {3'b0, entry_count}, 8'd0);
        check("R10 ovf", {7'b0, overflow}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            check($sformatf("R2/R3/R4/R5/R8 vec %0d byte", i), rd_byte, VEC[i][23:16]);
            check($sformatf("R1/R4/R8 vec %0d count", i), {3'b0, entry_count}, {3'b0, VEC[i][15:11]});
            check($sformatf("R6 vec %0d ovf", i), {7'b0, overflow}, {7'b0, VEC[i][10]});
            drive(VEC[i][9], VEC[i][8:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // fill to capacity: R1
        for (int k = 0; k < 16; k++) drive(1'b1, 6'(k), 1'b0, 1'b1, 1'b0);
        check("R1 full count", {3'b0, entry_count}, 8'd16);
        check("R2 full head", rd_byte, 8'h80);

        // one more event while full: R6
        drive(1'b1, 6'd20, 1'b0, 1'b1, 1'b0);
        check("R6 overflow set", {7'b0, overflow}, 8'd1);
        check("R6 count held", {3'b0, entry_count}, 8'd16);
        check("R7 overflow code", rd_byte, 8'h7E);

        // read the overflow report: R7
        drive(1'b0, 6'd0, 1'b0, 1'b1, 1'b1);
        check("R7 overflow cleared", {7'b0, overflow}, 8'd0);
        check("R7 nothing popped", {3'b0, entry_count}, 8'd16);
        check("R7 head intact", rd_byte, 8'h80);

        // push and pop together at full depth: R8
        drive(1'b1, 6'd30, 1'b0, 1'b1, 1'b1);
        check("R8 full push+pop count", {3'b0, entry_count}, 8'd16);
        check("R8 no overflow", {7'b0, overflow}, 8'd0);

        // drain and check order: R9
        for (int k = 0; k < 16; k++) begin
            logic [5:0] exp_key;
            exp_key = (k < 15) ? 6'(k + 1) : 6'd30;
            check($sformatf("R9 drain %0d", k), rd_byte, {(k < 15), 1'b0, exp_key});
            drive(1'b0, 6'd0, 1'b0, 1'b1, 1'b1);
        end
        check("R5 empty after drain", rd_byte, 8'h3F);
        check("R1 count zero", {3'b0, entry_count}, 8'd0);

        finish_run();
    end

endmodule